// File: doc/BRIEF.md
# Asynchronous Character Receiver with Flow-Control Filter

This block turns an asynchronous serial line into characters. A 2-flop synchronizer first brings the line into the clock domain. A 16x oversampling enable then times the samples. The block finds each start bit and reads 5 to 8 data bits, least significant bit first. It then samples the stop bit. Each finished character is offered once, as a single-cycle pulse, on a write port toward a receive FIFO.

Software can ask for the two in-band flow-control codes to be dropped, so they never reach the FIFO. The codes are usually the resume and pause characters, and they arrive as configuration inputs. Reacting to those codes is left to other logic. This block only decides whether each character is kept or discarded.

A receiver enable input gates the whole block. With the enable low, the line is not looked at.

Top module: `async_rx_xflt`

## Requirements
- R1: `len_sel_i` selects the data bits per character: 2'b00 gives 8, 2'b01 gives 7, 2'b10 gives 6 and 2'b11 gives 5. The value is latched when a start bit is accepted.
- R2: While `rx_en_i` is 0, the line is ignored. No character is assembled, and `wr_valid_o`, `frame_err_o` and `overflow_o` stay 0.
- R3: With `flt_en_i` = 0, every received character is offered on `wr_valid_o`. This includes characters equal to `xon_code_i` or `xoff_code_i`.
- R4: With `flt_en_i` = 1, a character equal to `xon_code_i` or `xoff_code_i` is discarded and never offered. Any other character is offered.
- R5: A falling edge starts a character only if the line is still low at the 8th oversample tick, counting the detecting tick as tick 0. If it is not, the receiver returns to idle and produces nothing.
- R6: Data bits are taken LSB first. They are presented right-aligned on `wr_data_o`, and the bits above the character length are 0.
- R7: A stop bit sampled low raises `frame_err_o` for exactly one cycle. The character is still offered, or filtered, as usual.
- R8: The match against the flow-control codes compares only the active low-order character bits. Code bits above the length are ignored.
- R9: Dropping `rx_en_i` during a character discards it, with no data and no error. The receiver is idle and ready for a fresh start bit once re-enabled.
- R10: If `wr_ready_i` is 0 in the cycle a character is offered, that character is lost and `overflow_o` pulses for one cycle. A character removed by the filter never causes an overflow.
- R11: `wr_valid_o` is high for exactly one cycle per stored character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16x oversampling enable, one cycle wide |
| rxd_i | input | 1 | Serial receive line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| flt_en_i | input | 1 | Drop flow-control characters when 1 |
| len_sel_i | input | 2 | Character length code |
| xon_code_i | input | 8 | Resume flow-control code |
| xoff_code_i | input | 8 | Pause flow-control code |
| wr_valid_o | output | 1 | Character offered to the FIFO |
| wr_data_o | output | 8 | Right-aligned character |
| wr_ready_i | input | 1 | FIFO can accept a character |
| frame_err_o | output | 1 | Stop bit was low (pulse) |
| overflow_o | output | 1 | Character lost, FIFO not ready (pulse) |

## Verification
The bench targets three kinds of failure:

- **Length and filter handling.** A short character compared on all eight bits would let a masked flow-control code leak into the FIFO. A wrong length decode would shift or truncate data, and stale upper bits would corrupt short characters.
- **Start-bit qualification.** A brief low glitch must not produce a phantom character. Likewise, the tail of a low stop bit must not be taken as a start bit.
- **Disabling and back-pressure.** Dropping the enable mid-character must not emit a truncated byte or a late framing error. A filtered character seen while the FIFO is not ready must not be counted as an overflow.

// File: rtl/async_rx_pkg.sv
`timescale 1ns/1ps
package async_rx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  // code 00 -> 8 bits ... 11 -> 5 bits
  function automatic logic [3:0] len_of(logic [1:0] code);
    return 4'd8 - {2'b00, code};
  endfunction

  function automatic logic [DATA_W-1:0] len_mask(logic [3:0] n);
    return {DATA_W{1'b1}} >> (4'd8 - n);
  endfunction
endpackage

// File: rtl/async_rx_framer.sv
`timescale 1ns/1ps
module async_rx_framer
  import async_rx_pkg::*;
#(
  parameter int unsigned OVS  = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              en_i,
  input  logic [1:0]        len_sel_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic [3:0]        len_o,
  output logic              stop_err_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned MID   = OVS / 2 - 1;

  logic [SYNC-1:0]   sync_q;
  logic              rxd_s;
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        bit_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] data_q;
  logic [3:0]        len_q;
  logic              done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-2:0], rxd_i};
  end
  assign rxd_s = sync_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      len_q   <= 4'd8;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rxd_s) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            // sample index is cnt_q+1; qualify at the middle sample
            if (cnt_q == CNT_W'(MID - 1)) begin
              cnt_q <= '0;
              if (!rxd_s) begin
                state_q <= ST_DATA;
                bit_q   <= '0;
                sh_q    <= '0;
                len_q   <= len_of(len_sel_i);
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == CNT_W'(OVS - 1)) begin
              cnt_q <= '0;
              sh_q  <= {rxd_s, sh_q[DATA_W-1:1]};
              if ({1'b0, bit_q} == len_q - 4'd1) state_q <= ST_STOP;
              else                               bit_q   <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == CNT_W'(OVS - 1)) begin
              cnt_q   <= '0;
              done_q  <= 1'b1;
              err_q   <= !rxd_s;
              data_q  <= sh_q >> (4'd8 - len_q);
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o     = done_q;
  assign data_o     = data_q;
  assign len_o      = len_q;
  assign stop_err_o = err_q;

  AST_DONE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(en_i)); // R2
  AST_DIS_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE)); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((data_o & ~len_mask(len_o)) == '0)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_o >= 4'd5) && (len_o <= 4'd8)); // R1
endmodule

// File: rtl/async_rx_store_filter.sv
`timescale 1ns/1ps
module async_rx_store_filter
  import async_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [3:0]        len_i,
  input  logic              stop_err_i,
  input  logic              flt_en_i,
  input  logic [DATA_W-1:0] xon_i,
  input  logic [DATA_W-1:0] xoff_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              overflow_o
);
  logic [DATA_W-1:0] mask;
  logic              hit, keep;

  assign mask = len_mask(len_i);
  assign hit  = (((data_i ^ xon_i) & mask) == '0) || (((data_i ^ xoff_i) & mask) == '0);
  assign keep = !(flt_en_i && hit);

  assign valid_o     = done_i && keep;
  assign data_o      = data_i;
  assign frame_err_o = done_i && stop_err_i;
  assign overflow_o  = valid_o && !ready_i;

  AST_NO_FLT_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !flt_en_i) |-> valid_o); // R3
  AST_FLT_NO_XON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flt_en_i) |-> (((data_o ^ xon_i) & mask) != '0)); // R4
  AST_FLT_NO_XOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flt_en_i) |-> (((data_o ^ xoff_i) & mask) != '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> !overflow_o); // R10
  AST_FE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o); // R7
endmodule

// File: rtl/async_rx_xflt.sv
`timescale 1ns/1ps
module async_rx_xflt
  import async_rx_pkg::*;
#(
  parameter int unsigned OVS  = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic              flt_en_i,
  input  logic [1:0]        len_sel_i,
  input  logic [DATA_W-1:0] xon_code_i,
  input  logic [DATA_W-1:0] xoff_code_i,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              frame_err_o,
  output logic              overflow_o
);
  logic              done;
  logic [DATA_W-1:0] data;
  logic [3:0]        len;
  logic              stop_err;

  async_rx_framer #(.OVS(OVS), .SYNC(SYNC)) i_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .rxd_i      (rxd_i),
    .en_i       (rx_en_i),
    .len_sel_i  (len_sel_i),
    .done_o     (done),
    .data_o     (data),
    .len_o      (len),
    .stop_err_o (stop_err)
  );

  async_rx_store_filter i_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .data_i      (data),
    .len_i       (len),
    .stop_err_i  (stop_err),
    .flt_en_i    (flt_en_i),
    .xon_i       (xon_code_i),
    .xoff_i      (xoff_code_i),
    .ready_i     (wr_ready_i),
    .valid_o     (wr_valid_o),
    .data_o      (wr_data_o),
    .frame_err_o (frame_err_o),
    .overflow_o  (overflow_o)
  );

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o); // R11
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rx_en_i) |-> !(wr_valid_o || frame_err_o || overflow_o)); // R2
endmodule

// File: tb/test_async_rx_xflt.sv
`timescale 1ns/1ps
module test_async_rx_xflt;
  localparam int BIT_CLKS = 64; // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] div = '0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b0;
  logic       flt_en = 1'b0;
  logic [1:0] len_sel = '0;
  logic [7:0] xon = 8'h11;
  logic [7:0] xoff = 8'h13;
  logic       ready = 1'b1;
  logic       wr_valid, frame_err, overflow;
  logic [7:0] wr_data;

  int n_chk = 0, n_fail = 0;
  int n_store = 0, n_ovf = 0, n_fe = 0, n_dbl = 0;
  logic [7:0] last_data = '0;
  logic prev_v = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  async_rx_xflt i_async_rx_xflt (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .rx_en_i(rx_en), .flt_en_i(flt_en), .len_sel_i(len_sel),
    .xon_code_i(xon), .xoff_code_i(xoff),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .wr_ready_i(ready),
    .frame_err_o(frame_err), .overflow_o(overflow)
  );

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (wr_valid && ready) begin n_store++; last_data = wr_data; end
      if (overflow)  n_ovf++;
      if (frame_err) n_fe++;
      if (wr_valid && prev_v) n_dbl++;
      prev_v = wr_valid;
    end
  end

  function automatic int f_len(logic [1:0] s);
    return 8 - int'(s);
  endfunction

  function automatic logic [7:0] f_mask(logic [1:0] s);
    return 8'hFF >> (8 - f_len(s));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] b, bit stop_ok);
    int len;
    len = f_len(len_sel);
    rxd = 1'b0; hold(BIT_CLKS);
    for (int i = 0; i < len; i++) begin rxd = b[i]; hold(BIT_CLKS); end
    rxd = stop_ok;
    if (stop_ok) hold(BIT_CLKS); else hold(40);
    rxd = 1'b1; hold(2 * BIT_CLKS);
  endtask

  task automatic do_frame(logic [7:0] b, bit stop_ok, string req);
    int s0, f0, o0;
    logic [7:0] m, exp_d;
    bit hit, keep;
    m     = f_mask(len_sel);
    exp_d = b & m;
    hit   = (((b ^ xon) & m) == 0) || (((b ^ xoff) & m) == 0);
    keep  = !(flt_en && hit);
    s0 = n_store; f0 = n_fe; o0 = n_ovf;
    send_frame(b, stop_ok);
    chk((n_store - s0) == int'(keep && ready), req, "stored count", n_store - s0, int'(keep && ready));
    if (keep && ready)
      chk(last_data == exp_d, req, "data", last_data, exp_d);
    chk((n_fe - f0) == int'(!stop_ok), req, "frame err count", n_fe - f0, int'(!stop_ok));
    chk((n_ovf - o0) == int'(keep && !ready), req, "overflow count", n_ovf - o0, int'(keep && !ready));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int s0, f0;
    hold(5);
    rst_n = 1'b1;
    hold(3);
    chk(!wr_valid && !frame_err && !overflow, "R2", "reset outputs", {wr_valid, frame_err, overflow}, 0);

    // R2: disabled receiver ignores the line
    s0 = n_store; f0 = n_fe;
    send_frame(8'h5A, 1'b0);
    chk(n_store == s0 && n_fe == f0, "R2", "activity while disabled", n_store - s0 + n_fe - f0, 0);

    rx_en = 1'b1;
    hold(BIT_CLKS);
    // R1 / R6: every length code
    for (int c = 0; c < 4; c++) begin
      len_sel = c[1:0];
      do_frame(8'hB6, 1'b1, "R1");
      do_frame(8'h3D, 1'b1, "R6");
    end
    len_sel = 2'b00;

    // R3: filter off stores control codes
    flt_en = 1'b0;
    do_frame(8'h11, 1'b1, "R3");
    do_frame(8'h13, 1'b1, "R3");
    chk(last_data == 8'h13, "R3", "xoff stored", last_data, 8'h13);

    // R4: filter on drops them, keeps others
    flt_en = 1'b1;
    s0 = n_store;
    do_frame(8'h11, 1'b1, "R4");
    do_frame(8'h13, 1'b1, "R4");
    chk(n_store == s0, "R4", "control codes dropped", n_store - s0, 0);
    do_frame(8'h12, 1'b1, "R4");

    // R8: only active bits compared
    len_sel = 2'b01; xon = 8'h91;
    s0 = n_store;
    do_frame(8'h11, 1'b1, "R8");
    chk(n_store == s0, "R8", "masked match dropped", n_store - s0, 0);
    len_sel = 2'b11; xoff = 8'hE7;
    do_frame(8'h07, 1'b1, "R8");
    len_sel = 2'b00; xon = 8'h11; xoff = 8'h13; flt_en = 1'b0;

    // R5: short glitch is rejected
    s0 = n_store; f0 = n_fe;
    rxd = 1'b0; hold(16); rxd = 1'b1; hold(4 * BIT_CLKS);
    chk(n_store == s0 && n_fe == f0, "R5", "glitch produced output", n_store - s0 + n_fe - f0, 0);
    do_frame(8'hC3, 1'b1, "R5");

    // R7: low stop bit
    do_frame(8'h6E, 1'b0, "R7");

    // R9: disable mid-character
    s0 = n_store; f0 = n_fe;
    rxd = 1'b0; hold(BIT_CLKS);
    for (int i = 0; i < 3; i++) begin rxd = i[0]; hold(BIT_CLKS); end
    rx_en = 1'b0;
    for (int i = 3; i < 8; i++) begin rxd = i[0]; hold(BIT_CLKS); end
    rxd = 1'b0; hold(40); rxd = 1'b1; hold(BIT_CLKS);
    rx_en = 1'b1; hold(2 * BIT_CLKS);
    chk(n_store == s0 && n_fe == f0, "R9", "partial character output", n_store - s0 + n_fe - f0, 0);
    do_frame(8'h2B, 1'b1, "R9");

    // R10: back-pressure
    ready = 1'b0;
    do_frame(8'h44, 1'b1, "R10");
    flt_en = 1'b1;
    do_frame(8'h11, 1'b1, "R10");
    ready = 1'b1; flt_en = 1'b0;

    // random mix
    void'($urandom(32'h1234));
    for (int k = 0; k < 70; k++) begin
      logic [7:0] b;
      logic [31:0] r;
      r       = $urandom();
      len_sel = r[1:0];
      flt_en  = r[2];
      ready   = (r[7:4] != 0);
      xon     = $urandom();
      xoff    = $urandom();
      b       = $urandom();
      if (r[9:8] == 2'd0) b = xon;
      else if (r[9:8] == 2'd1) b = xoff;
      do_frame(b, r[15:12] != 0, flt_en ? "R4" : "R3");
    end
    ready = 1'b1;

    chk(n_dbl == 0, "R11", "multi-cycle valid", n_dbl, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule